// File: doc/BRIEF.md
# Floating-Point to 32-Bit Integer Converter

This unit turns one IEEE 754 binary value into a 32-bit integer. The input may be half, single or double precision, selected per operation by a 2-bit size code. The result is either an unsigned integer or a two's-complement signed integer. A per-operation truncate bit forces rounding toward zero. When that bit is clear, a 3-bit dynamic rounding mode chooses among six rounding rules. The conversion has no fraction bits: the output is a plain integer.

All inputs are sampled on every rising clock edge. The result and its flags are registered and appear one clock later. Out-of-range values saturate to the nearest limit and raise the invalid flag. NaN inputs give zero and raise invalid. Discarded fraction bits raise the inexact flag when the result did not saturate. Subnormal inputs are converted exactly and round to 0 or ±1.

Top module: `f2i_convert`

## Requirements
- R1: Size code 2'b01 selects half precision, 2'b10 selects single and 2'b11 selects double. Size code 2'b00 sets the undefined flag and clears the result, invalid and inexact.
- R2: A half-precision input uses only operand[15:0], and a single-precision input uses only operand[31:0]. The remaining upper bits have no effect on the outputs.
- R3: The outputs update on the clock edge after the inputs are sampled and hold until the next edge. An active-low reset clears every output to zero.
- R4: When is_signed is 0 the result is unsigned. When it is 1 the result is a two's-complement signed integer.
- R5: When trunc_ovr is 1 the rounding is toward zero, whatever value rnd_mode carries.
- R6: rnd_mode encodes the rounding rule: 3'd0 nearest with ties to even, 3'd1 toward +infinity, 3'd2 toward -infinity, 3'd3 toward zero, 3'd4 nearest with ties away from zero, 3'd5 round to odd. Codes 3'd6 and 3'd7 behave like 3'd0.
- R7: A rounded value outside the result range saturates and sets invalid. The unsigned range is 0 to 32'hFFFFFFFF. The signed range is 32'h80000000 to 32'h7FFFFFFF.
- R8: In unsigned mode, a negative input whose rounded magnitude is nonzero gives 0 and sets invalid. A negative input that rounds to zero gives 0 without invalid.
- R9: A NaN input gives 0 and sets invalid. An infinity saturates to the limit of its sign and sets invalid.
- R10: Inexact is set when nonzero fraction bits were discarded and the result did not saturate. Invalid and inexact are never set together.
- R11: Subnormal inputs are converted exactly and give 0 or ±1, depending on the rounding rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand | input | 64 | Floating-point operand; narrower formats occupy the low bits |
| size_code | input | 2 | Input precision select (R1) |
| is_signed | input | 1 | 1 gives a signed result, 0 an unsigned result |
| trunc_ovr | input | 1 | 1 forces rounding toward zero |
| rnd_mode | input | 3 | Dynamic rounding rule (R6) |
| result | output | 32 | Registered integer result |
| invalid | output | 1 | Registered invalid flag: NaN, infinity or out of range |
| inexact | output | 1 | Registered inexact flag |
| undef | output | 1 | Registered flag for an illegal size code |

## Verification
The embedded properties are checked on every cycle:
- An illegal size code always leaves a quiet zero result and clears the other flags.
- Invalid and inexact are never set together.
- Every invalid result is one of the legal saturation values for the signedness of the previous cycle.
- The rounding stage only increments when fraction bits were actually discarded.

The exact integer values need the bench's scenarios. These cover each rounding rule on positive and negative ties, truncation overriding the dynamic mode, the boundaries at 2^31 and 2^32, subnormals, NaN, infinities and the masking of unused operand bits.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    localparam int OPW  = 64;
    localparam int RESW = 32;
    localparam int SIGW = 53;
    localparam int EXPW = 13;
    localparam int IW   = RESW + 2;
    localparam int MAGW = IW + 1;
    localparam int SHW  = SIGW + IW + 1;
    localparam int AMTW = $clog2(IW + 1);

    localparam logic [1:0] SZ_BAD    = 2'b00;
    localparam logic [1:0] SZ_HALF   = 2'b01;
    localparam logic [1:0] SZ_SINGLE = 2'b10;
    localparam logic [1:0] SZ_DOUBLE = 2'b11;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_UP        = 3'd1,
        RM_DOWN      = 3'd2,
        RM_ZERO      = 3'd3,
        RM_NEAR_AWAY = 3'd4,
        RM_ODD       = 3'd5
    } rmode_e;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [OPW-1:0]         operand,
    input  logic [1:0]             size_code,
    output logic                   sign,
    output logic                   is_nan,
    output logic                   is_inf,
    output logic                   undef,
    output logic signed [EXPW-1:0] exp_unb,
    output logic [SIGW-1:0]        sig
);
    logic [10:0]     e_raw;
    logic [10:0]     bias;
    logic [SIGW-2:0] frac;
    logic            all_ones;
    logic            zero_exp;

    always_comb begin
        sign     = 1'b0;
        e_raw    = '0;
        bias     = '0;
        frac     = '0;
        all_ones = 1'b0;
        undef    = 1'b0;
        unique case (size_code)
            SZ_HALF: begin
                sign     = operand[15];
                e_raw    = {6'd0, operand[14:10]};
                frac     = {operand[9:0], 42'd0};
                all_ones = &operand[14:10];
                bias     = 11'd15;
            end
            SZ_SINGLE: begin
                sign     = operand[31];
                e_raw    = {3'd0, operand[30:23]};
                frac     = {operand[22:0], 29'd0};
                all_ones = &operand[30:23];
                bias     = 11'd127;
            end
            SZ_DOUBLE: begin
                sign     = operand[63];
                e_raw    = operand[62:52];
                frac     = operand[51:0];
                all_ones = &operand[62:52];
                bias     = 11'd1023;
            end
            default: undef = 1'b1;
        endcase
        zero_exp = (e_raw == '0);
        is_nan   = all_ones & (|frac);
        is_inf   = all_ones & ~(|frac);
        sig      = {~zero_exp & ~undef, frac};
        exp_unb  = $signed({2'b00, (zero_exp ? 11'd1 : e_raw)}) - $signed({2'b00, bias});
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  logic                   sign,
    input  logic signed [EXPW-1:0] exp_unb,
    input  logic [SIGW-1:0]        sig,
    input  rmode_e                 mode,
    output logic [MAGW-1:0]        mag,
    output logic                   big,
    output logic                   lost,
    output logic                   inc
);
    logic [AMTW-1:0] amount;
    logic [SHW-1:0]  shifted;
    logic [IW-1:0]   int_part;
    logic            guard;
    logic            sticky;

    always_comb begin
        if (exp_unb < -13'sd1)
            amount = '0;
        else if (exp_unb > 13'sd32)
            amount = AMTW'(IW);
        else
            amount = AMTW'(exp_unb + 13'sd2);
        shifted  = {{(SHW-SIGW){1'b0}}, sig} << amount;
        int_part = shifted[SHW-1:SIGW+1];
        guard    = shifted[SIGW];
        sticky   = |shifted[SIGW-1:0];
        big      = exp_unb > 13'sd31;
        lost     = guard | sticky;
        unique case (mode)
            RM_NEAR_EVEN: inc = guard & (sticky | int_part[0]);
            RM_UP:        inc = ~sign & lost;
            RM_DOWN:      inc = sign & lost;
            RM_NEAR_AWAY: inc = guard;
            RM_ODD:       inc = lost & ~int_part[0];
            default:      inc = 1'b0;
        endcase
        mag = {1'b0, int_part} + MAGW'(inc);
    end
endmodule

// File: rtl/f2i_saturate.sv
module f2i_saturate
    import f2i_pkg::*;
(
    input  logic            sign,
    input  logic            is_nan,
    input  logic            is_inf,
    input  logic            undef,
    input  logic            big,
    input  logic            lost,
    input  logic            is_signed,
    input  logic [MAGW-1:0] mag,
    output logic [RESW-1:0] res,
    output logic            inv,
    output logic            inx
);
    localparam logic [MAGW-1:0] S_MAX = MAGW'({1'b0, {(RESW-1){1'b1}}});
    localparam logic [MAGW-1:0] S_NEG = MAGW'({1'b1, {(RESW-1){1'b0}}});
    localparam logic [MAGW-1:0] U_MAX = MAGW'({RESW{1'b1}});

    logic huge;

    always_comb begin
        res  = '0;
        inv  = 1'b0;
        huge = is_inf | big;
        if (undef) begin
            inv = 1'b0;
        end else if (is_nan) begin
            inv = 1'b1;
        end else if (is_signed) begin
            if (!sign) begin
                if (huge || mag > S_MAX) begin
                    res = S_MAX[RESW-1:0];
                    inv = 1'b1;
                end else begin
                    res = mag[RESW-1:0];
                end
            end else begin
                if (huge || mag > S_NEG) begin
                    res = S_NEG[RESW-1:0];
                    inv = 1'b1;
                end else begin
                    res = '0 - mag[RESW-1:0];
                end
            end
        end else begin
            if (sign) begin
                inv = huge || (mag != '0);
            end else if (huge || mag > U_MAX) begin
                res = U_MAX[RESW-1:0];
                inv = 1'b1;
            end else begin
                res = mag[RESW-1:0];
            end
        end
        inx = ~undef & ~is_nan & ~inv & lost;
    end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [63:0]     operand,
    input  logic [1:0]      size_code,
    input  logic            is_signed,
    input  logic            trunc_ovr,
    input  logic [2:0]      rnd_mode,
    output logic [31:0]     result,
    output logic            invalid,
    output logic            inexact,
    output logic            undef
);
    logic                   sign, is_nan, is_inf, bad_size;
    logic signed [EXPW-1:0] exp_unb;
    logic [SIGW-1:0]        sig;
    logic [MAGW-1:0]        mag;
    logic                   big, lost, inc;
    logic [RESW-1:0]        res_d;
    logic                   inv_d, inx_d;
    rmode_e                 eff_mode;
    logic                   armed;

    always_comb begin
        if (trunc_ovr)
            eff_mode = RM_ZERO;
        else if (rnd_mode > 3'd5)
            eff_mode = RM_NEAR_EVEN;
        else
            eff_mode = rmode_e'(rnd_mode);
    end

    f2i_unpack u_unpack (
        .operand   (operand),
        .size_code (size_code),
        .sign      (sign),
        .is_nan    (is_nan),
        .is_inf    (is_inf),
        .undef     (bad_size),
        .exp_unb   (exp_unb),
        .sig       (sig)
    );

    f2i_round u_round (
        .sign    (sign),
        .exp_unb (exp_unb),
        .sig     (sig),
        .mode    (eff_mode),
        .mag     (mag),
        .big     (big),
        .lost    (lost),
        .inc     (inc)
    );

    f2i_saturate u_sat (
        .sign      (sign),
        .is_nan    (is_nan),
        .is_inf    (is_inf),
        .undef     (bad_size),
        .big       (big),
        .lost      (lost),
        .is_signed (is_signed),
        .mag       (mag),
        .res       (res_d),
        .inv       (inv_d),
        .inx       (inx_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            invalid <= 1'b0;
            inexact <= 1'b0;
            undef   <= 1'b0;
            armed   <= 1'b0;
        end else begin
            result  <= res_d;
            invalid <= inv_d;
            inexact <= inx_d;
            undef   <= bad_size;
            armed   <= 1'b1;
        end
    end

    // R1
    undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (result == '0 && !invalid && !inexact));

    // R1
    undef_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (undef == ($past(size_code) == SZ_BAD)));

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalid && inexact));

    // R7
    sat_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && invalid && $past(is_signed)) |->
        (result == 32'h7FFFFFFF || result == 32'h80000000 || result == 32'h0));

    // R7
    sat_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && invalid && !$past(is_signed)) |->
        (result == 32'hFFFFFFFF || result == 32'h0));

    // R6
    round_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> lost);
endmodule

// File: tb/f2i_convert_tb.sv
module f2i_convert_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  size_code = 2'b10;
    logic        is_signed = 1'b0;
    logic        trunc_ovr = 1'b0;
    logic [2:0]  rnd_mode = 3'd0;
    logic [31:0] result;
    logic        invalid, inexact, undef;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    f2i_convert u_dut (
        .clk(clk), .rst_n(rst_n), .operand(operand), .size_code(size_code),
        .is_signed(is_signed), .trunc_ovr(trunc_ovr), .rnd_mode(rnd_mode),
        .result(result), .invalid(invalid), .inexact(inexact), .undef(undef)
    );

    // {size, signed, trunc, mode, operand, result, invalid, inexact, undef}
    localparam int NV = 40;
    localparam logic [105:0] VEC [NV] = '{
        {2'b10,1'b1,1'b0,3'd0,64'h40200000,32'h00000002,3'b010}, // R6 2.5 even
        {2'b10,1'b1,1'b0,3'd1,64'h40200000,32'h00000003,3'b010}, // R6 2.5 up
        {2'b10,1'b1,1'b0,3'd2,64'h40200000,32'h00000002,3'b010}, // R6 2.5 down
        {2'b10,1'b1,1'b0,3'd3,64'h40200000,32'h00000002,3'b010}, // R6 2.5 zero
        {2'b10,1'b1,1'b0,3'd4,64'h40200000,32'h00000003,3'b010}, // R6 2.5 away
        {2'b10,1'b1,1'b0,3'd5,64'h40200000,32'h00000003,3'b010}, // R6 2.5 odd
        {2'b10,1'b1,1'b0,3'd0,64'hC0200000,32'hFFFFFFFE,3'b010}, // R6 -2.5 even
        {2'b10,1'b1,1'b0,3'd1,64'hC0200000,32'hFFFFFFFE,3'b010}, // R6 -2.5 up
        {2'b10,1'b1,1'b0,3'd2,64'hC0200000,32'hFFFFFFFD,3'b010}, // R6 -2.5 down
        {2'b10,1'b1,1'b0,3'd4,64'hC0200000,32'hFFFFFFFD,3'b010}, // R6 -2.5 away
        {2'b10,1'b1,1'b0,3'd5,64'hC0200000,32'hFFFFFFFD,3'b010}, // R6 -2.5 odd
        {2'b10,1'b1,1'b0,3'd0,64'h40600000,32'h00000004,3'b010}, // R6 3.5 even
        {2'b10,1'b1,1'b0,3'd7,64'h40600000,32'h00000004,3'b010}, // R6 code 7 as even
        {2'b10,1'b1,1'b1,3'd1,64'h40200000,32'h00000002,3'b010}, // R5 trunc beats up
        {2'b10,1'b1,1'b1,3'd2,64'hC0200000,32'hFFFFFFFE,3'b010}, // R5 trunc beats down
        {2'b10,1'b1,1'b0,3'd5,64'h40800000,32'h00000004,3'b000}, // R6 odd exact 4.0
        {2'b01,1'b1,1'b0,3'd3,64'hDEADBEEF12344100,32'h00000002,3'b010}, // R2 half masks
        {2'b10,1'b1,1'b0,3'd3,64'hFFFFFFFF40200000,32'h00000002,3'b010}, // R2 single masks
        {2'b11,1'b1,1'b0,3'd0,64'h3FF0000000000000,32'h00000001,3'b000}, // R1 double 1.0
        {2'b11,1'b0,1'b0,3'd0,64'h41EFFFFFFFE00000,32'hFFFFFFFF,3'b000}, // R4 2^32-1
        {2'b11,1'b0,1'b0,3'd0,64'h41F0000000000000,32'hFFFFFFFF,3'b100}, // R7 2^32 u
        {2'b11,1'b1,1'b0,3'd0,64'h41F0000000000000,32'h7FFFFFFF,3'b100}, // R7 2^32 s
        {2'b11,1'b1,1'b0,3'd0,64'hC1E0000000000000,32'h80000000,3'b000}, // R7 -2^31
        {2'b11,1'b1,1'b0,3'd0,64'h41DFFFFFFFE00000,32'h7FFFFFFF,3'b100}, // R7 tie over
        {2'b11,1'b1,1'b0,3'd3,64'h41DFFFFFFFE00000,32'h7FFFFFFF,3'b010}, // R7 fits trunc
        {2'b01,1'b0,1'b0,3'd3,64'h000000000000BE00,32'h00000000,3'b100}, // R8 -1.5 u
        {2'b10,1'b0,1'b0,3'd3,64'h00000000BF000000,32'h00000000,3'b010}, // R8 -0.5 u
        {2'b10,1'b1,1'b0,3'd0,64'h7FC00000,32'h00000000,3'b100}, // R9 NaN
        {2'b10,1'b1,1'b0,3'd0,64'h7F800000,32'h7FFFFFFF,3'b100}, // R9 +inf s
        {2'b10,1'b0,1'b0,3'd0,64'hFF800000,32'h00000000,3'b100}, // R9 -inf u
        {2'b01,1'b0,1'b0,3'd0,64'h7C00,32'hFFFFFFFF,3'b100},     // R9 half +inf u
        {2'b10,1'b1,1'b0,3'd1,64'h00000001,32'h00000001,3'b010}, // R11 subnormal up
        {2'b10,1'b1,1'b0,3'd0,64'h00000001,32'h00000000,3'b010}, // R11 subnormal even
        {2'b10,1'b1,1'b0,3'd2,64'h80000001,32'hFFFFFFFF,3'b010}, // R11 neg sub down
        {2'b00,1'b1,1'b0,3'd0,64'h40200000,32'h00000000,3'b001}, // R1 illegal size
        {2'b01,1'b1,1'b0,3'd3,64'h000000000000BE00,32'hFFFFFFFF,3'b010}, // R4 -1.5 s
        {2'b10,1'b0,1'b0,3'd0,64'h4F000000,32'h80000000,3'b000}, // R4 2^31 u
        {2'b10,1'b1,1'b0,3'd0,64'h4F000000,32'h7FFFFFFF,3'b100}, // R4 2^31 s
        {2'b11,1'b0,1'b0,3'd0,64'h8000000000000000,32'h00000000,3'b000}, // R8 -0.0 u
        {2'b01,1'b0,1'b0,3'd1,64'h0001,32'h00000001,3'b010}      // R11 half sub up
    };

    task automatic check(input string req, input logic [31:0] er,
                         input logic [2:0] ef);
        checks++;
        if (result !== er || {invalid, inexact, undef} !== ef) begin
            errors++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     req, result, {invalid, inexact, undef}, er, ef);
        end
    endtask

    task automatic apply(input logic [105:0] v);
        @(negedge clk);
        size_code = v[105:104];
        is_signed = v[103];
        trunc_ovr = v[102];
        rnd_mode  = v[101:99];
        operand   = v[98:35];
        @(posedge clk);
        #2;
    endtask

    initial begin
        #30000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R3 reset state", 32'h0, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("R-vector %0d", i), VEC[i][34:3], VEC[i][2:0]);
        end

        // R3: output holds until the next edge, then updates
        apply({2'b10,1'b1,1'b0,3'd1,64'h40200000,32'h3,3'b010});
        @(negedge clk);
        operand = 64'h40800000;
        rnd_mode = 3'd0;
        #2;
        check("R3 hold before edge", 32'h3, 3'b010);
        @(posedge clk);
        #2;
        check("R3 update after edge", 32'h4, 3'b000);

        // R3: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R3 async reset clears", 32'h0, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule